// File: doc/BRIEF.md
# Pause Flow-Control Register Bank

This block is the register bank that software uses to set up pause-based flow control in an Ethernet MAC. It sits on a simple register bus with one-cycle writes and registered reads. It also owns the small path that turns a pause notification from the receive side into a pause request for the transmitter. A build-time parameter selects one of two layouts.

In standard layout, the control register at offset 0x60A holds a single transmit pause-enable bit. A received pause reaches the transmitter only when that bit and the receive pause-enable bit at 0x605 are both set, and only when the frame matched the station address.

In priority layout, the same offset holds a 3-bit queue selector. The selector picks one row of an internal table with eight rows, one per queue. Each row holds a 16-bit retransmit holdoff value and a 16-bit pause quanta value. Software reaches the selected row through offsets 0x608 (holdoff) and 0x609 (quanta). In this layout there is no transmit enable bit, so the receive pause-enable bit alone gates the pause path.

Top module: `pause_ctl_regs`

## Requirements
- R1: After reset, every register and table row holds 0, `tx_pause_req` is 0 and `rdata` is 0.
- R2: Offset 0x605 bit 0 is the receive pause enable. It is read/write in both layouts.
- R3: In standard layout (PRIO_MODE=0), offset 0x60A bit 0 is the transmit pause enable. It is read/write, and bits [31:1] read as 0.
- R4: While the receive pause enable is 0, `tx_pause_req` stays 0 whatever `rx_pause_det`, `rx_addr_match` or the transmit enable hold.
- R5: `tx_pause_req` is 1 in the cycle after an edge at which all of these hold: `rx_pause_det`=1, `rx_addr_match`=1, receive enable=1, and (standard layout only) transmit enable=1. Otherwise it is 0 in that cycle. A notification without an address match never raises it.
- R6: In priority layout (PRIO_MODE=1), offset 0x60A bits [2:0] hold the queue number. It is read/write, and bits [31:3] read as 0.
- R7: In priority layout, offset 0x608 reads and writes the 16-bit holdoff value of the selected row in bits [15:0], and offset 0x609 does the same for the quanta value. Bits [31:16] read as 0.
- R8: A write to 0x608 or 0x609 changes only the row selected at the time of the write. A read issued in the cycle after a queue-number write returns the newly selected row.
- R9: Unmapped offsets (including 0x608/0x609 in standard layout) and unused bits read as 0. Writes to them change no state.
- R10: `rdata` takes the addressed value one clock after an edge with `rd_en`=1 and holds its value when `rd_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rx_pause_det | input | 1 | Receive side processed a pause frame |
| rx_addr_match | input | 1 | That pause frame matched the station address |
| tx_pause_req | output | 1 | Registered pause request to the transmitter |

## Verification
The bench drives both layouts side by side and goes after the cases where a design fails quietly. It exercises the two-enable gate with each enable cleared in turn, and a notification that arrives without an address match. A design that ORed the enables or ignored the match would raise a pause request there. It writes every row through the indirect window and reads each one back right after a selector change. A write that reached more than one row, or a selector update delayed by a cycle, would show up as a wrong row. It also writes all-ones to unmapped offsets and to unused bits. A decoder that aliased offsets or stored extra bits would return nonzero data.

// File: rtl/pause_regs_pkg.sv
package pause_regs_pkg;

  localparam int OFS_W  = 12;
  localparam int DATA_W = 32;

  localparam logic [OFS_W-1:0] OFS_RXEN = 12'h605;
  localparam logic [OFS_W-1:0] OFS_HOLD = 12'h608;
  localparam logic [OFS_W-1:0] OFS_QNT  = 12'h609;
  localparam logic [OFS_W-1:0] OFS_CTL  = 12'h60A;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_RXEN = 3'd1,
    SEL_HOLD = 3'd2,
    SEL_QNT  = 3'd3,
    SEL_CTL  = 3'd4
  } reg_sel_e;

  // Offset decode; the table window exists only in priority layout
  function automatic reg_sel_e decode_ofs(logic [OFS_W-1:0] a, bit prio);
    reg_sel_e s;
    s = SEL_NONE;
    if (a == OFS_RXEN)              s = SEL_RXEN;
    else if (a == OFS_CTL)          s = SEL_CTL;
    else if (prio && a == OFS_HOLD) s = SEL_HOLD;
    else if (prio && a == OFS_QNT)  s = SEL_QNT;
    return s;
  endfunction

  // Gate from a receive notification to a transmit request
  function automatic logic pause_pass(logic rx_en, logic tx_en, bit prio,
                                      logic det, logic match);
    return rx_en & (prio ? 1'b1 : tx_en) & det & match;
  endfunction

endpackage

// File: rtl/pause_decode.sv
module pause_decode
  import pause_regs_pkg::*;
#(
  parameter bit PRIO_MODE = 1'b1
) (
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] addr,
  output reg_sel_e         sel,
  output logic             wr_rxen,
  output logic             wr_ctl,
  output logic             wr_hold,
  output logic             wr_qnt,
  output logic             rd_unmapped
);

  always_comb begin
    sel         = decode_ofs(addr, PRIO_MODE);
    wr_rxen     = wr_en && (sel == SEL_RXEN);
    wr_ctl      = wr_en && (sel == SEL_CTL);
    wr_hold     = wr_en && (sel == SEL_HOLD);
    wr_qnt      = wr_en && (sel == SEL_QNT);
    rd_unmapped = rd_en && (sel == SEL_NONE);
  end

endmodule

// File: rtl/pause_qtable.sv
module pause_qtable #(
  parameter int NUM_Q = 8,
  parameter int QW    = 16,
  localparam int QSEL_W = $clog2(NUM_Q)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QSEL_W-1:0] qsel,
  input  logic              wr_hold,
  input  logic              wr_qnt,
  input  logic [QW-1:0]     wval,
  output logic [QW-1:0]     hold_o,
  output logic [QW-1:0]     qnt_o
);

  logic [QW-1:0]    hold_q [NUM_Q];
  logic [QW-1:0]    qnt_q  [NUM_Q];
  logic [NUM_Q-1:0] hold_we;
  logic [NUM_Q-1:0] qnt_we;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_row
    assign hold_we[i] = wr_hold && (qsel == QSEL_W'(i));
    assign qnt_we[i]  = wr_qnt  && (qsel == QSEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_q[i] <= '0;
        qnt_q[i]  <= '0;
      end else begin
        if (hold_we[i]) hold_q[i] <= wval;
        if (qnt_we[i])  qnt_q[i]  <= wval;
      end
    end

    AST_ROW_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_we[i] |=> $stable(hold_q[i])); // R8
    AST_ROW_QNT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !qnt_we[i] |=> $stable(qnt_q[i])); // R8
  end

  assign hold_o = hold_q[qsel];
  assign qnt_o  = qnt_q[qsel];

  AST_ONE_ROW_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hold_we) && $onehot0(qnt_we)); // R8

endmodule

// File: rtl/pause_gate.sv
module pause_gate
  import pause_regs_pkg::*;
#(
  parameter bit PRIO_MODE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic tx_en,
  input  logic det,
  input  logic match,
  output logic req
);

  logic pass;

  assign pass = pause_pass(rx_en, tx_en, PRIO_MODE, det, match);

  always_ff @(posedge clk) begin
    if (!rst_n) req <= 1'b0;
    else        req <= pass;
  end

  AST_NO_REQ_WITHOUT_RXEN: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !req); // R4
  AST_NO_REQ_WITHOUT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (det && !match) |=> !req); // R5
  AST_REQ_AFTER_NOTIFY: assert property (@(posedge clk) disable iff (!rst_n)
    (det && match && rx_en && (PRIO_MODE || tx_en)) |=> req); // R5

endmodule

// File: rtl/pause_ctl_regs.sv
module pause_ctl_regs
  import pause_regs_pkg::*;
#(
  parameter bit PRIO_MODE = 1'b1,
  parameter int NUM_Q     = 8,
  parameter int QW        = 16,
  localparam int QSEL_W   = $clog2(NUM_Q)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              rx_pause_det,
  input  logic              rx_addr_match,
  output logic              tx_pause_req
);

  reg_sel_e          sel;
  logic              wr_rxen, wr_ctl, wr_hold, wr_qnt, rd_unmapped;
  logic              rx_en_q;
  logic [QSEL_W-1:0] ctl_q;
  logic [QW-1:0]     hold_v, qnt_v;
  logic [DATA_W-1:0] rd_mux;

  pause_decode #(.PRIO_MODE(PRIO_MODE)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .sel(sel),
    .wr_rxen(wr_rxen), .wr_ctl(wr_ctl), .wr_hold(wr_hold),
    .wr_qnt(wr_qnt), .rd_unmapped(rd_unmapped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       rx_en_q <= 1'b0;
    else if (wr_rxen) rx_en_q <= wdata[0];
  end

  // Control register: queue selector or a single TX enable bit
  if (PRIO_MODE) begin : g_ctl_prio
    always_ff @(posedge clk) begin
      if (!rst_n)      ctl_q <= '0;
      else if (wr_ctl) ctl_q <= wdata[QSEL_W-1:0];
    end

    pause_qtable #(.NUM_Q(NUM_Q), .QW(QW)) u_tab (
      .clk(clk), .rst_n(rst_n), .qsel(ctl_q), .wr_hold(wr_hold),
      .wr_qnt(wr_qnt), .wval(wdata[QW-1:0]), .hold_o(hold_v), .qnt_o(qnt_v)
    );
  end else begin : g_ctl_std
    always_ff @(posedge clk) begin
      if (!rst_n)      ctl_q <= '0;
      else if (wr_ctl) ctl_q <= QSEL_W'(wdata[0]);
    end
    assign hold_v = '0;
    assign qnt_v  = '0;
  end

  always_comb begin
    unique case (sel)
      SEL_RXEN: rd_mux = DATA_W'(rx_en_q);
      SEL_CTL:  rd_mux = DATA_W'(ctl_q);
      SEL_HOLD: rd_mux = DATA_W'(hold_v);
      SEL_QNT:  rd_mux = DATA_W'(qnt_v);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  pause_gate #(.PRIO_MODE(PRIO_MODE)) u_gate (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en_q), .tx_en(ctl_q[0]),
    .det(rx_pause_det), .match(rx_addr_match), .req(tx_pause_req)
  );

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> (rdata == '0)); // R9
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R10
  AST_RXEN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rxen |=> $stable(rx_en_q)); // R2

endmodule

// File: tb/sim_pause_ctl_regs.sv
module sim_pause_ctl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        det = 1'b0, match = 1'b0;
  logic [31:0] d_rdata [2];
  logic        d_req   [2];

  int    total = 0, bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  // Instance 0: priority layout; instance 1: standard layout
  pause_ctl_regs #(.PRIO_MODE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(d_rdata[0]), .rx_pause_det(det),
    .rx_addr_match(match), .tx_pause_req(d_req[0]));
  pause_ctl_regs #(.PRIO_MODE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(d_rdata[1]), .rx_pause_det(det),
    .rx_addr_match(match), .tx_pause_req(d_req[1]));

  // Behavioural reference model, index 0 = priority, 1 = standard
  int          m_rxen [2];
  int          m_ctl  [2];
  int          m_hold [2][8];
  int          m_qnt  [2][8];
  logic [31:0] m_rdata [2];
  logic        m_req   [2];

  function automatic logic [31:0] mread(int k, logic [11:0] a);
    if (a == 12'h605) return 32'(m_rxen[k]);
    if (a == 12'h60A) return 32'(m_ctl[k]);
    if (k == 0 && a == 12'h608) return 32'(m_hold[k][m_ctl[k]]);
    if (k == 0 && a == 12'h609) return 32'(m_qnt[k][m_ctl[k]]);
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_rxen[k] = 0; m_ctl[k] = 0; m_rdata[k] = '0; m_req[k] = 1'b0;
        for (int q = 0; q < 8; q++) begin m_hold[k][q] = 0; m_qnt[k][q] = 0; end
      end else begin
        if (rd_en) m_rdata[k] = mread(k, addr);
        m_req[k] = (m_rxen[k] == 1) && (k == 0 || m_ctl[k] == 1) && det && match;
        if (wr_en) begin
          if (addr == 12'h605) m_rxen[k] = int'(wdata[0]);
          else if (addr == 12'h60A) m_ctl[k] = (k == 0) ? int'(wdata[2:0]) : int'(wdata[0]);
          else if (k == 0 && addr == 12'h608) m_hold[k][m_ctl[k]] = int'(wdata[15:0]);
          else if (k == 0 && addr == 12'h609) m_qnt[k][m_ctl[k]] = int'(wdata[15:0]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      for (int k = 0; k < 2; k++) begin
        total++;
        if (d_rdata[k] !== m_rdata[k]) begin
          bad++;
          $display("FAIL %s inst%0d rdata act=%h exp=%h", cur_req, k, d_rdata[k], m_rdata[k]);
        end
        total++;
        if (d_req[k] !== m_req[k]) begin
          bad++;
          $display("FAIL %s/R5 inst%0d tx_pause_req act=%b exp=%b", cur_req, k, d_req[k], m_req[k]);
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; det = 1'b0; match = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = a;
  endtask

  task automatic notify(logic d, logic m);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; det = d; match = m;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd(12'h605); rd(12'h60A); rd(12'h608); rd(12'h609); idle();

    cur_req = "R2";
    wr(12'h605, 32'h1); rd(12'h605); wr(12'h605, 32'hFFFF_FFFE); rd(12'h605);
    wr(12'h605, 32'h0000_0003); rd(12'h605); idle();

    cur_req = "R3/R6";
    wr(12'h60A, 32'hFFFF_FFFF); rd(12'h60A); wr(12'h60A, 32'h0000_0006); rd(12'h60A);
    wr(12'h60A, 32'h1); rd(12'h60A); idle();

    cur_req = "R4";
    wr(12'h605, 32'h0); notify(1, 1); notify(1, 1); idle(); idle();

    cur_req = "R5";
    wr(12'h605, 32'h1); notify(1, 1); notify(1, 0); notify(0, 1); notify(1, 1); idle();
    wr(12'h60A, 32'h0); notify(1, 1); idle(); idle();

    cur_req = "R7";
    for (int q = 0; q < 8; q++) begin
      wr(12'h60A, 32'(q));
      wr(12'h608, 32'hABCD_0000 | 32'(16'h1100 + q));
      wr(12'h609, 32'h5555_0000 | 32'(16'hF0F0 ^ q));
    end
    cur_req = "R8";
    for (int q = 7; q >= 0; q--) begin
      wr(12'h60A, 32'(q)); rd(12'h608); rd(12'h609);
    end
    wr(12'h60A, 32'h2); wr(12'h608, 32'hFFFF);
    wr(12'h60A, 32'h3); rd(12'h608); wr(12'h60A, 32'h2); rd(12'h608); idle();

    cur_req = "R9";
    wr(12'h600, 32'hFFFF_FFFF); wr(12'h607, 32'hFFFF_FFFF); wr(12'h60B, 32'hFFFF_FFFF);
    rd(12'h600); rd(12'h607); rd(12'h60B); rd(12'hFFF); rd(12'h605); rd(12'h60A);
    rd(12'h608); idle();

    cur_req = "R10";
    rd(12'h605);
    @(negedge clk); rd_en = 1'b0; addr = 12'h60A;
    @(negedge clk); addr = 12'h600;
    idle();

    cur_req = "R1-R10 mix";
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      case ($urandom % 6)
        0: a = 12'h605;
        1: a = 12'h608;
        2: a = 12'h609;
        3: a = 12'h60A;
        4: a = 12'h606;
        default: a = 12'(12'h600 + ($urandom % 16));
      endcase
      @(negedge clk);
      wr_en = ($urandom % 3) == 0;
      rd_en = ($urandom % 2) == 0;
      addr = a; wdata = $urandom;
      det = ($urandom % 2) == 0; match = ($urandom % 2) == 0;
    end
    idle(); idle();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule